// File: doc/BRIEF.md
# Hit Data Organizer

This block sits between a detector hit stream and a pattern-matching engine. During the collect phase it takes the full-resolution hits of one event, each tagged with a layer number. It files each hit into an on-chip store keyed by layer and coarse bin. The coarse bin, or super bin, is the fine bin address with its low-order bits dropped. The first time a layer-and-bin pair appears in the event, that super bin is sent once toward the matcher, provided the layer is enabled for forwarding. Layers that are not forwarded are still stored.

An end-of-event word closes the collect phase. The block echoes that word on the super-bin output and stops taking hits. It then accepts matched road identifiers. For each road it looks up one super bin per layer in a small road table, walks the stored hits of those bins, and emits a packet: a header word with the road identifier, then every stored hit of the road, with the final word flagged. An end-of-event word on the road input is echoed on the packet output. The store is then cleared, and the next event may begin.

Top module: `hit_data_organizer`

## Requirements
- R1: After reset, in_ready is 1, and sb_valid, rd_ready and pk_valid are 0.
- R2: The super bin of a hit is in_fine shifted right by SB_SHIFT (2 by default). Fine addresses 0x10 to 0x13 share super bin 4.
- R3: For an enabled layer, the first stored hit of each (layer, super bin) pair in an event produces exactly one super-bin word. The word has sb_eoe=0 and carries the layer and the bin. Later hits in the same pair produce no word.
- R4: A layer whose SEND_MASK bit is 0 produces no super-bin words. Its hits are still stored and appear in road packets. By default layer 0 is forwarded and layer 1 is not.
- R5: An input word with in_eoe=1 produces one super-bin word with sb_eoe=1. From then on in_ready stays 0 until the packet-side end-of-event word has been transferred.
- R6: A road packet starts with a header word: pk_kind=0, pk_data=road id. Hit words follow: pk_kind=1, pk_data={layer, fine}. Layers appear in ascending order. Within one layer's bin, hits appear newest first.
- R7: pk_last is 1 on the final word of every packet. A road with no stored hit in any of its bins is a lone header with pk_last=1. A layer with an empty bin contributes no words.
- R8: A road word with rd_eoe=1 produces one packet word with pk_kind=2, pk_last=0 and pk_data=0. The store is then empty for the next event: earlier hits are never retrieved, and super bins are forwarded afresh.
- R9: At most DEPTH hits (32 by default) are stored per event. Any further hits are accepted and discarded, and they forward no super bin.
- R10: While an output is valid and not ready, its word stays unchanged.
- R11: A write on the rt_* port sets the super bin that a road uses for the given layer. Later packets for that road use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Hit word valid |
| in_ready | output | 1 | Hit word accepted |
| in_eoe | input | 1 | Word is end of event |
| in_layer | input | 1 | Hit layer |
| in_fine | input | 8 | Full-resolution bin address |
| sb_valid | output | 1 | Super-bin word valid |
| sb_ready | input | 1 | Matcher takes super-bin word |
| sb_eoe | output | 1 | Super-bin word is end of event |
| sb_layer | output | 1 | Layer of forwarded bin |
| sb_bin | output | 6 | Forwarded super bin |
| rd_valid | input | 1 | Road word valid |
| rd_ready | output | 1 | Road word accepted |
| rd_eoe | input | 1 | No more roads this event |
| rd_id | input | 4 | Matched road identifier |
| pk_valid | output | 1 | Packet word valid |
| pk_ready | input | 1 | Packet word taken |
| pk_kind | output | 2 | 0 header, 1 hit, 2 end of event |
| pk_last | output | 1 | Final word of a road packet |
| pk_data | output | 9 | Road id or {layer, fine} |
| rt_we | input | 1 | Road table write |
| rt_road | input | 4 | Road table entry |
| rt_layer | input | 1 | Layer of entry |
| rt_sb | input | 6 | Super bin written |

## Verification
The bench targets repeated hits that share a super bin. A design that forwarded on every hit would emit duplicate super-bin words, and one that appended instead of prepending would reverse the packet order. Non-forwarded layers are checked for storage, since a design that filtered at the store would drop their hits from packets. Roads whose first layer is empty, or that are wholly empty, are checked because a wrong last flag or a wrong layer hand-over shows up there. The bench also checks overflow past the store depth and a hit-free event that follows a full one. Either case exposes a store that keeps stale bins or forwards dropped hits.

// File: rtl/hds_pkg.sv
package hds_pkg;
    typedef enum logic [1:0] {
        PK_HDR = 2'd0,
        PK_HIT = 2'd1,
        PK_EOE = 2'd2
    } pk_kind_e;

    typedef enum logic [2:0] {
        ST_COLLECT  = 3'd0,
        ST_ROADWAIT = 3'd1,
        ST_HDR      = 3'd2,
        ST_HIT      = 3'd3,
        ST_EOE      = 3'd4
    } phase_e;
endpackage

// File: rtl/hds_road_table.sv
module hds_road_table #(
    parameter int NUM_ROADS  = 16,
    parameter int NUM_LAYERS = 2,
    parameter int SB_W       = 6,
    parameter int RW         = 4,
    parameter int LW         = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [RW-1:0]              wr_road,
    input  logic [LW-1:0]              wr_layer,
    input  logic [SB_W-1:0]            wr_sb,
    input  logic [RW-1:0]              rd_road,
    output logic [NUM_LAYERS*SB_W-1:0] rd_sb
);
    localparam int ENTRIES = NUM_ROADS * NUM_LAYERS;

    logic [SB_W-1:0] tbl_q [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
        end else if (we && int'(wr_layer) < NUM_LAYERS && int'(wr_road) < NUM_ROADS) begin
            tbl_q[int'(wr_road) * NUM_LAYERS + int'(wr_layer)] <= wr_sb;
        end
    end

    for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_rd
        assign rd_sb[g*SB_W +: SB_W] = tbl_q[int'(rd_road) * NUM_LAYERS + g];
    end
endmodule

// File: rtl/hds_hit_store.sv
module hds_hit_store #(
    parameter int DEPTH  = 32,
    parameter int KW     = 7,
    parameter int FINE_W = 8,
    parameter int NRD    = 2,
    localparam int PW    = $clog2(DEPTH),
    localparam int KEYS  = 1 << KW,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [KW-1:0]     wr_key,
    input  logic [FINE_W-1:0] wr_fine,
    output logic              wr_first,
    output logic              full,
    input  logic [NRD*KW-1:0] lk_key,
    output logic [NRD*PW-1:0] lk_head,
    output logic [NRD-1:0]    lk_vld,
    input  logic [PW-1:0]     rd_ptr,
    output logic [FINE_W-1:0] rd_fine,
    output logic [PW-1:0]     rd_next,
    output logic              rd_end
);
    logic [KEYS-1:0]   vld_q, vld_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [PW-1:0]     head_q [KEYS];
    logic [FINE_W-1:0] data_q [DEPTH];
    logic [PW-1:0]     nxt_q  [DEPTH];
    logic [DEPTH-1:0]  end_q;
    logic              wr_go;
    logic [PW-1:0]     wp;

    assign full     = (cnt_q == CW'(DEPTH));
    assign wr_go    = wr_en && !full && !clr;
    assign wp       = cnt_q[PW-1:0];
    assign wr_first = !vld_q[wr_key];

    always_comb begin
        vld_d = vld_q;
        cnt_d = cnt_q;
        if (clr) begin
            vld_d = '0;
            cnt_d = '0;
        end else if (wr_go) begin
            vld_d[wr_key] = 1'b1;
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            cnt_q <= '0;
        end else begin
            vld_q <= vld_d;
            cnt_q <= cnt_d;
        end
    end

    // new hit is pushed at the head of its bin list
    always_ff @(posedge clk) begin
        if (wr_go) begin
            data_q[wp]     <= wr_fine;
            nxt_q[wp]      <= head_q[wr_key];
            end_q[wp]      <= !vld_q[wr_key];
            head_q[wr_key] <= wp;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_lk
        assign lk_vld[g]           = vld_q[lk_key[g*KW +: KW]];
        assign lk_head[g*PW +: PW] = head_q[lk_key[g*KW +: KW]];
    end

    assign rd_fine = data_q[rd_ptr];
    assign rd_next = nxt_q[rd_ptr];
    assign rd_end  = end_q[rd_ptr];

    p_drop_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !clr) |=> (cnt_q == CW'(DEPTH)));
    p_clear_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (vld_q == '0 && cnt_q == '0));
endmodule

// File: rtl/hit_data_organizer.sv
module hit_data_organizer
    import hds_pkg::*;
#(
    parameter int FINE_W     = 8,
    parameter int SB_SHIFT   = 2,
    parameter int NUM_LAYERS = 2,
    parameter int DEPTH      = 32,
    parameter int NUM_ROADS  = 16,
    parameter logic [NUM_LAYERS-1:0] SEND_MASK = 2'b01,
    localparam int SB_W = FINE_W - SB_SHIFT,
    localparam int LW   = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1,
    localparam int RW   = $clog2(NUM_ROADS),
    localparam int HW   = LW + FINE_W,
    localparam int DW   = (HW > RW) ? HW : RW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_eoe,
    input  logic [LW-1:0]     in_layer,
    input  logic [FINE_W-1:0] in_fine,
    output logic              sb_valid,
    input  logic              sb_ready,
    output logic              sb_eoe,
    output logic [LW-1:0]     sb_layer,
    output logic [SB_W-1:0]   sb_bin,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic              rd_eoe,
    input  logic [RW-1:0]     rd_id,
    output logic              pk_valid,
    input  logic              pk_ready,
    output logic [1:0]        pk_kind,
    output logic              pk_last,
    output logic [DW-1:0]     pk_data,
    input  logic              rt_we,
    input  logic [RW-1:0]     rt_road,
    input  logic [LW-1:0]     rt_layer,
    input  logic [SB_W-1:0]   rt_sb
);
    localparam int KW = LW + SB_W;
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        phase_e                 ph;
        logic                   sbv;
        logic                   sbe;
        logic [LW-1:0]          sbl;
        logic [SB_W-1:0]        sbb;
        logic [RW-1:0]          rid;
        logic [LW-1:0]          cur;
        logic [PW-1:0]          ptr;
        logic [NUM_LAYERS-1:0]  hv;
        logic [NUM_LAYERS*PW-1:0] hd;
    } st_t;

    st_t q, d;

    logic                      wr_en, clr, wr_first, full;
    logic [NUM_LAYERS*SB_W-1:0] road_sb;
    logic [NUM_LAYERS*KW-1:0]  lk_key;
    logic [NUM_LAYERS*PW-1:0]  lk_head;
    logic [NUM_LAYERS-1:0]     lk_vld;
    logic [FINE_W-1:0]         rd_fine;
    logic [PW-1:0]             rd_next;
    logic                      rd_end;
    logic [SB_W-1:0]           in_sb;
    logic                      lay_ok;
    logic [LW-1:0]             first_l, after_l;
    logic                      has_after;

    assign in_sb  = in_fine[FINE_W-1:SB_SHIFT];
    assign lay_ok = int'(in_layer) < NUM_LAYERS;

    hds_road_table #(
        .NUM_ROADS(NUM_ROADS), .NUM_LAYERS(NUM_LAYERS), .SB_W(SB_W), .RW(RW), .LW(LW)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .we(rt_we), .wr_road(rt_road), .wr_layer(rt_layer),
        .wr_sb(rt_sb), .rd_road(rd_id), .rd_sb(road_sb)
    );

    for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_key
        assign lk_key[g*KW +: KW] = {LW'(g), road_sb[g*SB_W +: SB_W]};
    end

    hds_hit_store #(
        .DEPTH(DEPTH), .KW(KW), .FINE_W(FINE_W), .NRD(NUM_LAYERS)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en),
        .wr_key({in_layer, in_sb}), .wr_fine(in_fine), .wr_first(wr_first), .full(full),
        .lk_key(lk_key), .lk_head(lk_head), .lk_vld(lk_vld),
        .rd_ptr(q.ptr), .rd_fine(rd_fine), .rd_next(rd_next), .rd_end(rd_end)
    );

    // lowest non-empty layer overall, and lowest one above the current layer
    always_comb begin
        first_l   = '0;
        after_l   = '0;
        has_after = 1'b0;
        for (int l = NUM_LAYERS - 1; l >= 0; l--) begin
            if (q.hv[l]) first_l = LW'(l);
            if (q.hv[l] && l > int'(q.cur)) begin
                after_l   = LW'(l);
                has_after = 1'b1;
            end
        end
    end

    always_comb begin
        d        = q;
        wr_en    = 1'b0;
        clr      = 1'b0;
        in_ready = (q.ph == ST_COLLECT) && !q.sbv;
        rd_ready = (q.ph == ST_ROADWAIT);
        pk_valid = (q.ph == ST_HDR) || (q.ph == ST_HIT) || (q.ph == ST_EOE);
        pk_kind  = PK_HDR;
        pk_last  = 1'b0;
        pk_data  = '0;

        if (sb_valid && sb_ready) d.sbv = 1'b0;

        if (in_valid && in_ready) begin
            if (in_eoe) begin
                d.sbv = 1'b1;
                d.sbe = 1'b1;
                d.ph  = ST_ROADWAIT;
            end else if (lay_ok) begin
                wr_en = 1'b1;
                if (!full && wr_first && SEND_MASK[in_layer]) begin
                    d.sbv = 1'b1;
                    d.sbe = 1'b0;
                    d.sbl = in_layer;
                    d.sbb = in_sb;
                end
            end
        end

        if (rd_valid && rd_ready) begin
            if (rd_eoe) begin
                d.ph = ST_EOE;
            end else begin
                d.rid = rd_id;
                d.hv  = lk_vld;
                d.hd  = lk_head;
                d.ph  = ST_HDR;
            end
        end

        case (q.ph)
            ST_HDR: begin
                pk_kind = PK_HDR;
                pk_data = DW'(q.rid);
                pk_last = !(|q.hv);
                if (pk_ready) begin
                    if (|q.hv) begin
                        d.cur = first_l;
                        d.ptr = q.hd[int'(first_l)*PW +: PW];
                        d.ph  = ST_HIT;
                    end else begin
                        d.ph = ST_ROADWAIT;
                    end
                end
            end
            ST_HIT: begin
                pk_kind = PK_HIT;
                pk_data = DW'({q.cur, rd_fine});
                pk_last = rd_end && !has_after;
                if (pk_ready) begin
                    if (!rd_end) begin
                        d.ptr = rd_next;
                    end else if (has_after) begin
                        d.cur = after_l;
                        d.ptr = q.hd[int'(after_l)*PW +: PW];
                    end else begin
                        d.ph = ST_ROADWAIT;
                    end
                end
            end
            ST_EOE: begin
                pk_kind = PK_EOE;
                if (pk_ready) begin
                    clr  = 1'b1;
                    d.ph = ST_COLLECT;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sb_valid = q.sbv;
    assign sb_eoe   = q.sbe;
    assign sb_layer = q.sbl;
    assign sb_bin   = q.sbb;

    p_pk_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_valid && !pk_ready) |=> (pk_valid && $stable(pk_kind) && $stable(pk_data) && $stable(pk_last)));
    p_sb_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_valid && !sb_ready) |=> (sb_valid && $stable(sb_eoe) && $stable(sb_layer) && $stable(sb_bin)));
    p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pk_valid |-> !in_ready);
    p_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_valid && pk_ready && pk_last) |=> !(pk_valid && pk_kind == PK_HIT));
    p_masked_layer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_valid && !sb_eoe) |-> SEND_MASK[sb_layer]);
endmodule

// File: tb/sim_hit_data_organizer.sv
module sim_hit_data_organizer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH_B = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, in_eoe = 0, in_layer = 0;
    logic [7:0] in_fine = 0;
    logic in_ready;
    logic sb_valid, sb_eoe, sb_layer;
    logic sb_ready = 0;
    logic [5:0] sb_bin;
    logic rd_valid = 0, rd_eoe = 0;
    logic [3:0] rd_id = 0;
    logic rd_ready;
    logic pk_valid, pk_last;
    logic pk_ready = 0;
    logic [1:0] pk_kind;
    logic [8:0] pk_data;
    logic rt_we = 0, rt_layer = 0;
    logic [3:0] rt_road = 0;
    logic [5:0] rt_sb = 0;

    int checks = 0, errors = 0, cyc = 0;
    int got_sb[$], got_pk[$], exp_sb[$], exp_pk[$];
    int ev_l[$], ev_f[$], ev_r[$], st_l[$], st_f[$];
    int road_sb[16][2];
    bit seen[int];

    hit_data_organizer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_eoe(in_eoe),
        .in_layer(in_layer), .in_fine(in_fine), .sb_valid(sb_valid), .sb_ready(sb_ready),
        .sb_eoe(sb_eoe), .sb_layer(sb_layer), .sb_bin(sb_bin), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_eoe(rd_eoe), .rd_id(rd_id), .pk_valid(pk_valid),
        .pk_ready(pk_ready), .pk_kind(pk_kind), .pk_last(pk_last), .pk_data(pk_data),
        .rt_we(rt_we), .rt_road(rt_road), .rt_layer(rt_layer), .rt_sb(rt_sb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int enc(int kind, int last, int data);
        return kind * 65536 + last * 4096 + data;
    endfunction

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d exp %0d", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog got %0d exp 0", cyc);
            finish_run();
        end
    end

    // output monitor: set ready, then record what transfers at the next edge
    always @(negedge clk) begin
        sb_ready = ($urandom % 4) != 0;
        pk_ready = ($urandom % 4) != 0;
        #1;
        if (rst_n && sb_valid && sb_ready)
            got_sb.push_back(sb_eoe ? -1 : int'(sb_layer) * 256 + int'(sb_bin));
        if (rst_n && pk_valid && pk_ready)
            got_pk.push_back(enc(int'(pk_kind), int'(pk_last), int'(pk_data)));
    end

    task automatic put_in(bit eoe, int l, int f);
        @(negedge clk);
        in_valid = 1; in_eoe = eoe; in_layer = l[0]; in_fine = f[7:0];
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk);
    endtask

    task automatic put_rd(bit eoe, int r);
        @(negedge clk);
        rd_valid = 1; rd_eoe = eoe; rd_id = r[3:0];
        #1;
        while (!rd_ready) begin @(negedge clk); #1; end
        @(posedge clk);
    endtask

    task automatic rt_write(int r, int l, int sb);
        @(negedge clk);
        rt_we = 1; rt_road = r[3:0]; rt_layer = l[0]; rt_sb = sb[5:0];
        road_sb[r][l] = sb;
        @(negedge clk);
        rt_we = 0;
    endtask

    task automatic build_expect();
        exp_sb.delete(); exp_pk.delete(); st_l.delete(); st_f.delete(); seen.delete();
        foreach (ev_l[i]) begin
            int k = ev_l[i] * 256 + (ev_f[i] >> 2);
            if (st_l.size() < DEPTH_B) begin
                if (!seen.exists(k)) begin
                    seen[k] = 1;
                    if (ev_l[i] == 0) exp_sb.push_back(k);
                end
                st_l.push_back(ev_l[i]);
                st_f.push_back(ev_f[i]);
            end
        end
        exp_sb.push_back(-1);
        foreach (ev_r[j]) begin
            int w[$];
            for (int l = 0; l < 2; l++)
                for (int i = st_l.size() - 1; i >= 0; i--)
                    if (st_l[i] == l && (st_f[i] >> 2) == road_sb[ev_r[j]][l])
                        w.push_back(l * 256 + st_f[i]);
            exp_pk.push_back(enc(0, w.size() == 0, ev_r[j]));
            foreach (w[m]) exp_pk.push_back(enc(1, m == w.size() - 1, w[m]));
        end
        exp_pk.push_back(enc(2, 0, 0));
    endtask

    task automatic run_event(string tsb, string tpk);
        int t;
        got_sb.delete(); got_pk.delete();
        build_expect();
        foreach (ev_l[i]) put_in(0, ev_l[i], ev_f[i]);
        put_in(1, 0, 0);
        @(negedge clk);
        in_valid = 0;
        #2;
        chk("R5 in_ready held off", int'(in_ready), 0);
        foreach (ev_r[j]) put_rd(0, ev_r[j]);
        put_rd(1, 0);
        @(negedge clk);
        rd_valid = 0;
        t = 0;
        while (!(got_pk.size() > 0 && got_pk[got_pk.size()-1] == enc(2, 0, 0)) && t < 5000) begin
            @(negedge clk); t++;
        end
        t = 0;
        while (!(got_sb.size() > 0 && got_sb[got_sb.size()-1] == -1) && t < 5000) begin
            @(negedge clk); t++;
        end
        repeat (2) @(negedge clk);
        chk({tsb, " sb count"}, got_sb.size(), exp_sb.size());
        foreach (exp_sb[i]) chk({tsb, " sb word"}, (i < got_sb.size()) ? got_sb[i] : -99, exp_sb[i]);
        chk({tpk, " pk count"}, got_pk.size(), exp_pk.size());
        foreach (exp_pk[i]) chk({tpk, " pk word"}, (i < got_pk.size()) ? got_pk[i] : -99, exp_pk[i]);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 in_ready", int'(in_ready), 1);
        chk("R1 sb_valid", int'(sb_valid), 0);
        chk("R1 rd_ready", int'(rd_ready), 0);
        chk("R1 pk_valid", int'(pk_valid), 0);

        for (int r = 0; r < 16; r++)
            for (int l = 0; l < 2; l++) rt_write(r, l, (r * 3 + l) % 12);

        // directed: shared bins, unforwarded layer, empty layers and roads
        rt_write(3, 0, 4);  rt_write(3, 1, 4);
        rt_write(5, 0, 5);  rt_write(5, 1, 7);
        rt_write(6, 0, 10); rt_write(6, 1, 10);
        rt_write(7, 0, 11); rt_write(7, 1, 9);
        ev_l = '{0, 0, 1, 0, 0, 1};
        ev_f = '{8'h10, 8'h11, 8'h12, 8'h14, 8'h13, 8'h24};
        ev_r = '{3, 5, 6, 7};
        run_event("R2 R3 R4", "R6 R7");

        // directed: overflow of the store
        ev_l.delete(); ev_f.delete();
        for (int i = 0; i < 40; i++) begin ev_l.push_back(0); ev_f.push_back(i * 4); end
        rt_write(8, 0, 31); rt_write(8, 1, 0);
        rt_write(9, 0, 33); rt_write(9, 1, 1);
        ev_r = '{8, 9};
        run_event("R9", "R9");

        // directed: hit-free event after a full one, road table rewrite
        rt_write(8, 0, 20);
        ev_l.delete(); ev_f.delete();
        ev_r = '{3, 8};
        run_event("R8", "R8 R11");

        // random events with random backpressure
        for (int e = 0; e < 25; e++) begin
            int n = $urandom % 38;
            ev_l.delete(); ev_f.delete(); ev_r.delete();
            for (int i = 0; i < n; i++) begin
                ev_l.push_back($urandom % 2);
                ev_f.push_back($urandom % 48);
            end
            rt_write($urandom % 16, $urandom % 2, $urandom % 12);
            rt_write($urandom % 16, $urandom % 2, $urandom % 12);
            for (int j = 0; j < int'($urandom % 6); j++) ev_r.push_back($urandom % 16);
            run_event("R3 R10", "R6 R7 R10 R11");
        end

        finish_run();
    end
endmodule